// File: doc/BRIEF.md
# Timed Fuse and Lock Access Controller

This block sits beside a CPU's program-memory read path and gives self-programming software a narrow, cycle-counted route to the device's nonvolatile configuration bits. Software arms the block by writing a control register with both a store-enable bit and a lock-set bit. That opens a short window. In the first part of the window, a load strobe returns a configuration byte chosen by the Z address instead of flash data. Anywhere in the window, a store strobe clears boot-lock bits.

The arming state clears itself once a load or store is taken, or once the window runs out. A busy signal from the EEPROM writer freezes the control register and blocks configuration reads and lock programming. The fuse bytes are parameters. The six lock bits live in internal registers, and a programmed lock bit is stored as 0.

Top module: `cfgbit_access_ctrl`

## Requirements
- R1: After reset, `armed` is 0, every lock bit is 1 (the lock byte reads 0xFF), and loads return `mem_rdata`.
- R2: A control write with `ee_busy` low sets `armed` only when `ctl_store_en` and `ctl_lock_set` are both 1. A control write with only one of them set leaves the block disarmed, and clears `armed` if it was set.
- R3: An armed load in cycle 0, 1 or 2 after the arming edge returns a configuration byte instead of memory data. Z=0x0000 selects fuse low (default 0xE1), 0x0001 the lock byte, 0x0002 the extended fuse byte and 0x0003 fuse high (default 0x99).
- R4: A load taken under R3 clears `armed`. Later loads return `mem_rdata`.
- R5: A load in cycle 3 after arming returns `mem_rdata` and leaves `armed` set. A store is still accepted in that cycle.
- R6: If no load or store is taken, `armed` is high for exactly four cycles (cycles 0 to 3) and then clears.
- R7: A store strobe while armed does three things. For each `st_boot_bits` bit k (data bits 5..2) that is 0, it clears lock bit k+2. It leaves lock bits 1..0 unchanged. It clears `armed`. A store while disarmed changes nothing.
- R8: Lock bits can only go from 1 to 0. A 1 in the store data never sets a bit.
- R9: In the lock byte, bits 7..6 read 1, bits 5..4 are the boot-section lock, bits 3..2 are the application-section lock and bits 1..0 are the general lock. The extended fuse byte reads 1 in bits 7..2 above its two fuse bits (default 01), so it reads 0xFD.
- R10: While `ee_busy` is 1, three things hold. Control writes have no effect. Armed loads return `mem_rdata` and do not end the window. Stores program nothing and do not end the window.
- R11: An armed load in cycles 0 to 2 whose Z is above 0x0003 returns `mem_rdata` and clears `armed`.
- R12: While disarmed, `rd_data` equals `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_store_en | input | 1 | Store-enable bit of the written control value |
| ctl_lock_set | input | 1 | Lock-set bit of the written control value |
| ee_busy | input | 1 | EEPROM write in progress |
| ld_strobe | input | 1 | Program-memory load in this cycle |
| z_addr | input | 16 | Load address |
| mem_rdata | input | 8 | Normal program-memory read data |
| st_strobe | input | 1 | Store in this cycle |
| st_boot_bits | input | 4 | Store data bits 5..2 (0 programs the lock bit) |
| rd_data | output | 8 | Load result (combinational) |
| armed | output | 1 | Arming bits currently set |

## Verification
The assertions assume three things about the inputs. A control write never lands in the same cycle as a load or a store. A load and a store never coincide. The inputs change only between clock edges. The stimulus drives all inputs on the falling edge and issues one action per cycle, so each case keeps to these assumptions. The window counter is covered by holding idle cycles before each strobe, and by running cases with `ee_busy` raised after the block is armed.

// File: rtl/cfgacc_pkg.sv
package cfgacc_pkg;

   typedef enum logic [1:0] {
      SEL_FUSE_LO = 2'd0,
      SEL_LOCK    = 2'd1,
      SEL_FUSE_EX = 2'd2,
      SEL_FUSE_HI = 2'd3
   } cfg_sel_e;

   localparam int LOCK_W     = 6;
   localparam int BOOT_LO    = 2;
   localparam int BOOT_W     = 4;

endpackage

// File: rtl/cfgacc_arm_timer.sv
module cfgacc_arm_timer #(
   parameter int LD_WIN = 3,
   parameter int ST_WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_both,
   input  logic ee_busy,
   input  logic ld_hit,
   input  logic st_hit,
   output logic armed,
   output logic ld_open
);

   localparam int CW = $clog2(ST_WIN + 1);

   logic [CW-1:0] age;
   logic          last_cycle;

   assign last_cycle = (age == CW'(ST_WIN - 1));
   assign ld_open    = armed && (age < CW'(LD_WIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         age   <= '0;
      end else if (ctl_wr && !ee_busy) begin
         armed <= ctl_both;
         age   <= '0;
      end else if (armed) begin
         if (ld_hit || st_hit || last_cycle) begin
            armed <= 1'b0;
            age   <= '0;
         end else begin
            age   <= age + 1'b1;
         end
      end
   end

   // R6
   window_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && last_cycle && !ctl_wr |=> !armed);

   // R10
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ee_busy && !armed |=> !armed);

   // R4
   hit_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hit || st_hit) && !ctl_wr |=> !armed);

   // R5
   age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> age < CW'(ST_WIN));

endmodule

// File: rtl/cfgacc_lock_store.sv
module cfgacc_lock_store
   import cfgacc_pkg::*;
#(
   parameter logic [LOCK_W-1:0] LOCK_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_hit,
   input  logic [BOOT_W-1:0] st_boot_bits,
   output logic [LOCK_W-1:0] lock_bits
);

   for (genvar i = 0; i < LOCK_W; i++) begin : g_bit
      if (i >= BOOT_LO && i < BOOT_LO + BOOT_W) begin : g_prog
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      lock_bits[i] <= LOCK_INIT[i];
            else if (st_hit) lock_bits[i] <= lock_bits[i] & st_boot_bits[i-BOOT_LO];
         end
      end else begin : g_fixed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lock_bits[i] <= LOCK_INIT[i];
            else        lock_bits[i] <= lock_bits[i];
         end
      end
   end

   // R8
   lock_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lock_bits & ~$past(lock_bits)) == '0);

   // R7
   store_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_hit |=> lock_bits == $past(lock_bits));

endmodule

// File: rtl/cfgacc_read_mux.sv
module cfgacc_read_mux
   import cfgacc_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter int              DATA_W   = 8,
   parameter int              EXT_W    = 2,
   parameter logic [DATA_W-1:0] FUSE_LO  = 8'hE1,
   parameter logic [DATA_W-1:0] FUSE_HI  = 8'h99,
   parameter logic [EXT_W-1:0]  FUSE_EXT = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_open,
   input  logic              ld_strobe,
   input  logic              ee_busy,
   input  logic [ADDR_W-1:0] z_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [LOCK_W-1:0] lock_bits,
   output logic [DATA_W-1:0] rd_data,
   output logic              ld_hit
);

   logic [DATA_W-1:0] lock_byte;
   logic [DATA_W-1:0] ext_byte;
   logic              z_cfg;
   cfg_sel_e          sel;

   if (DATA_W > LOCK_W) begin : g_lock_pad
      assign lock_byte = {{(DATA_W-LOCK_W){1'b1}}, lock_bits};
   end else begin : g_lock_nopad
      assign lock_byte = lock_bits[DATA_W-1:0];
   end

   if (DATA_W > EXT_W) begin : g_ext_pad
      assign ext_byte = {{(DATA_W-EXT_W){1'b1}}, FUSE_EXT};
   end else begin : g_ext_nopad
      assign ext_byte = FUSE_EXT[DATA_W-1:0];
   end

   assign z_cfg  = (z_addr[ADDR_W-1:2] == '0);
   assign sel    = cfg_sel_e'(z_addr[1:0]);
   assign ld_hit = ld_strobe && ld_open && !ee_busy;

   always_comb begin
      rd_data = mem_rdata;
      if (ld_hit && z_cfg) begin
         unique case (sel)
            SEL_FUSE_LO: rd_data = FUSE_LO;
            SEL_LOCK:    rd_data = lock_byte;
            SEL_FUSE_EX: rd_data = ext_byte;
            SEL_FUSE_HI: rd_data = FUSE_HI;
         endcase
      end
   end

   // R12
   unarmed_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_open |-> rd_data == mem_rdata);

   // R9
   lock_pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hit && z_addr == ADDR_W'(1) |-> rd_data[DATA_W-1:LOCK_W] == '1);

endmodule

// File: rtl/cfgbit_access_ctrl.sv
module cfgbit_access_ctrl
   import cfgacc_pkg::*;
#(
   parameter int                 ADDR_W    = 16,
   parameter int                 DATA_W    = 8,
   parameter int                 LD_WIN    = 3,
   parameter int                 ST_WIN    = 4,
   parameter int                 EXT_W     = 2,
   parameter logic [DATA_W-1:0]  FUSE_LO   = 8'hE1,
   parameter logic [DATA_W-1:0]  FUSE_HI   = 8'h99,
   parameter logic [EXT_W-1:0]   FUSE_EXT  = 2'b01,
   parameter logic [LOCK_W-1:0]  LOCK_INIT = 6'h3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_store_en,
   input  logic              ctl_lock_set,
   input  logic              ee_busy,
   input  logic              ld_strobe,
   input  logic [ADDR_W-1:0] z_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              st_strobe,
   input  logic [BOOT_W-1:0] st_boot_bits,
   output logic [DATA_W-1:0] rd_data,
   output logic              armed
);

   if (LD_WIN < 1 || LD_WIN > ST_WIN) begin : g_bad_win
      $error("load window must be 1..ST_WIN");
   end
   if (DATA_W < LOCK_W || EXT_W > DATA_W || ADDR_W < 3) begin : g_bad_width
      $error("width parameters out of range");
   end

   logic                ld_open;
   logic                ld_hit;
   logic                st_hit;
   logic [LOCK_W-1:0]   lock_bits;

   assign st_hit = st_strobe && armed && !ee_busy;

   cfgacc_arm_timer #(
      .LD_WIN (LD_WIN),
      .ST_WIN (ST_WIN)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_both (ctl_store_en && ctl_lock_set),
      .ee_busy  (ee_busy),
      .ld_hit   (ld_hit),
      .st_hit   (st_hit),
      .armed    (armed),
      .ld_open  (ld_open)
   );

   cfgacc_lock_store #(
      .LOCK_INIT (LOCK_INIT)
   ) i_lock (
      .clk          (clk),
      .rst_n        (rst_n),
      .st_hit       (st_hit),
      .st_boot_bits (st_boot_bits),
      .lock_bits    (lock_bits)
   );

   cfgacc_read_mux #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .EXT_W    (EXT_W),
      .FUSE_LO  (FUSE_LO),
      .FUSE_HI  (FUSE_HI),
      .FUSE_EXT (FUSE_EXT)
   ) i_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_open   (ld_open),
      .ld_strobe (ld_strobe),
      .ee_busy   (ee_busy),
      .z_addr    (z_addr),
      .mem_rdata (mem_rdata),
      .lock_bits (lock_bits),
      .rd_data   (rd_data),
      .ld_hit    (ld_hit)
   );

   // R10
   busy_store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_busy && !ctl_wr |=> lock_bits == $past(lock_bits));

   // R2
   single_bit_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !ee_busy && !(ctl_store_en && ctl_lock_set) |=> !armed);

endmodule

// File: tb/test_cfgbit_access_ctrl.sv
module test_cfgbit_access_ctrl;

   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 0, ctl_store_en = 0, ctl_lock_set = 0, ee_busy = 0;
   logic        ld_strobe = 0, st_strobe = 0;
   logic [15:0] z_addr = '0;
   logic [7:0]  mem_rdata = '0;
   logic [3:0]  st_boot_bits = '1;
   logic [7:0]  rd_data;
   logic        armed;

   int n_vec = 0;
   int n_bad = 0;

   // behavioural reference state
   int         m_armed = 0;
   int         m_age = 0;
   logic [5:0] m_lock = 6'h3F;

   always #(CLK_P/2) clk = ~clk;

   cfgbit_access_ctrl i_cfgbit_access_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_store_en(ctl_store_en),
      .ctl_lock_set(ctl_lock_set), .ee_busy(ee_busy), .ld_strobe(ld_strobe),
      .z_addr(z_addr), .mem_rdata(mem_rdata), .st_strobe(st_strobe),
      .st_boot_bits(st_boot_bits), .rd_data(rd_data), .armed(armed));

   function automatic logic [7:0] model_rd();
      logic [7:0] r;
      r = mem_rdata;
      if (m_armed != 0 && m_age < 3 && ld_strobe && !ee_busy && z_addr < 16'd4) begin
         case (z_addr[1:0])
            2'd0: r = 8'hE1;
            2'd1: r = {2'b11, m_lock};
            2'd2: r = 8'hFD;
            default: r = 8'h99;
         endcase
      end
      return r;
   endfunction

   task automatic model_tick();
      bit take_ld, take_st;
      take_ld = (m_armed != 0) && m_age < 3 && ld_strobe && !ee_busy;
      take_st = (m_armed != 0) && st_strobe && !ee_busy;
      if (take_st)
         for (int k = 0; k < 4; k++)
            if (!st_boot_bits[k]) m_lock[k+2] = 1'b0;
      if (ctl_wr && !ee_busy) begin
         m_armed = (ctl_store_en && ctl_lock_set) ? 1 : 0;
         m_age = 0;
      end else if (m_armed != 0) begin
         if (take_ld || take_st || m_age == 3) begin
            m_armed = 0;
            m_age = 0;
         end else m_age++;
      end
   endtask

   task automatic step(input bit wr, input bit se, input bit ls, input bit busy,
                       input bit ld, input logic [15:0] z, input logic [7:0] mem,
                       input bit st, input logic [3:0] sb, input string tag);
      logic [7:0] exp_rd;
      ctl_wr = wr; ctl_store_en = se; ctl_lock_set = ls; ee_busy = busy;
      ld_strobe = ld; z_addr = z; mem_rdata = mem; st_strobe = st; st_boot_bits = sb;
      #2;
      exp_rd = model_rd();
      n_vec++;
      if (rd_data !== exp_rd) begin
         n_bad++;
         $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_rd);
      end
      n_vec++;
      if (armed !== (m_armed != 0)) begin
         n_bad++;
         $display("FAIL %s armed actual=%b expected=%0d", tag, armed, m_armed);
      end
      @(posedge clk);
      model_tick();
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step(0,0,0,0, 0,16'h0,8'h5A, 0,4'hF, tag);
   endtask
   task automatic arm(input string tag);
      step(1,1,1,0, 0,16'h0,8'h11, 0,4'hF, tag);
   endtask
   task automatic load(input logic [15:0] z, input logic [7:0] mem, input string tag);
      step(0,0,0,0, 1,z,mem, 0,4'hF, tag);
   endtask
   task automatic store(input logic [3:0] sb, input string tag);
      step(0,0,0,0, 0,16'h1234,8'h22, 1,sb, tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1");
      load(16'h0001, 8'h3C, "R1");
      load(16'h0000, 8'hA7, "R12");
      // R2: one arming bit alone
      step(1,1,0,0, 0,16'h0,8'h00, 0,4'hF, "R2");
      idle("R2");
      step(1,0,1,0, 0,16'h0,8'h00, 0,4'hF, "R2");
      idle("R2");
      arm("R2");
      step(1,1,0,0, 0,16'h0,8'h00, 0,4'hF, "R2");
      idle("R2");
      // R3 / R4
      arm("R3");
      load(16'h0000, 8'h44, "R3");
      load(16'h0000, 8'h45, "R4");
      arm("R3");
      idle("R3"); idle("R3");
      load(16'h0003, 8'h46, "R3");
      arm("R9");
      load(16'h0002, 8'h47, "R9");
      arm("R9");
      idle("R9");
      load(16'h0001, 8'h48, "R9");
      // R5 / R6
      arm("R5");
      idle("R6"); idle("R6"); idle("R6");
      load(16'h0001, 8'h49, "R5");
      idle("R6");
      arm("R6");
      idle("R6"); idle("R6"); idle("R6"); idle("R6"); idle("R6");
      // R7: store in last window cycle, bit3 programmed
      arm("R7");
      idle("R7"); idle("R7"); idle("R7");
      store(4'b1101, "R7");
      idle("R7");
      arm("R7");
      load(16'h0001, 8'h00, "R7");
      // R8: ones never restore
      arm("R8");
      store(4'b1111, "R8");
      arm("R8");
      load(16'h0001, 8'h00, "R8");
      // R7: store while disarmed
      store(4'b0000, "R7");
      arm("R7");
      load(16'h0001, 8'h00, "R7");
      // R10: busy
      arm("R10");
      step(1,0,0,1, 0,16'h0,8'h00, 0,4'hF, "R10");
      step(0,0,0,1, 1,16'h0001,8'h77, 0,4'hF, "R10");
      step(0,0,0,1, 0,16'h0,8'h00, 1,4'b0000, "R10");
      load(16'h0001, 8'h78, "R10");
      idle("R10");
      step(1,1,1,1, 0,16'h0,8'h00, 0,4'hF, "R10");
      idle("R10");
      // R11
      arm("R11");
      load(16'h0100, 8'h9E, "R11");
      idle("R11");
      arm("R11");
      load(16'h0005, 8'h9F, "R11");
      load(16'h0001, 8'hA0, "R12");
      // R7: clear remaining boot bits
      arm("R7");
      store(4'b0000, "R7");
      arm("R9");
      load(16'h0001, 8'h00, "R9");
      load(16'h0001, 8'h00, "R12");
      idle("R12");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule